// File: doc/BRIEF.md
# Dual-Bus Register Set

This block is a small register file of four byte-wide registers that sits between two shared, bidirectional data buses, called A and B. Each bus has its own 2-bit register number, a load strobe and a drive strobe. In a single clock cycle each bus can do one of three things:

- write the byte on it into the addressed register;
- read the addressed register onto itself;
- stay idle.

Because the two buses are independent, two operations can take place in the same cycle.

Each register has its own pair of tri-state output drivers, one per bus. An input selector picks which bus a register captures from. A one-hot decoder per bus turns the register number into per-register selects. Storage is written on the rising edge of one system clock, and the strobes only enable that write. A synchronous active-low reset clears every register.

Top module: `dual_bus_regset`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, all four registers are cleared to 0x00.
- R2: A register number n (00, 01, 10, 11) on `num_a` or `num_b` addresses register n, and only that register.
- R3: With `ld_a` high, the byte on `bus_a` at the rising edge is stored in register `num_a`. No other register changes unless it is addressed by a bus B load.
- R4: With `ld_b` high, the byte on `bus_b` at the rising edge is stored in register `num_b`. No other register changes unless it is addressed by a bus A load.
- R5: With `drv_a` high, `bus_a` carries the current content of register `num_a` in the same cycle, before the edge. The same holds for `drv_b`, `bus_b` and `num_b`. With the drive strobe low, no register drives that bus.
- R6: The two buses operate independently in the same cycle. A register read on one bus while being written from the other shows its old value in that cycle and the new value afterwards.
- R7: When `ld_a` and `ld_b` address the same register in one cycle, the value from bus A is stored.
- R8: In a cycle with both load strobes low, no register changes, whatever the drive strobes do.
- R9: When drive and load are both active on one bus, the addressed register drives the bus and recaptures the driven byte, so its content is unchanged.
- R10: At most one register drives a given bus at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_a | inout | 8 | Shared bidirectional data bus A |
| bus_b | inout | 8 | Shared bidirectional data bus B |
| ld_a | input | 1 | Load strobe for bus A |
| ld_b | input | 1 | Load strobe for bus B |
| drv_a | input | 1 | Drive strobe for bus A |
| drv_b | input | 1 | Drive strobe for bus B |
| num_a | input | 2 | Register number used by bus A |
| num_b | input | 2 | Register number used by bus B |

## Verification
The functions that share a cycle are a read on one bus and a write on the other, and two writes, one per bus. Random stimulus gives each bus its own operation and its own register number every cycle, so that collisions on a single register come up often. Directed cycles force a read of the very register being written, and a write of one register from both buses at once.

The bench judges each read against a model that updates only after the edge, which is how it checks old-then-new ordering. Its model applies bus B before bus A, which makes bus A win a shared target. Values written and values read are also compared in later cycles.

// File: rtl/regset_pkg.sv
// Package: shared sizing defaults for the dual-bus register set.
// Assumes: register count is a power of two.
package regset_pkg;
    parameter int REG_W  = 8;
    parameter int REG_N  = 4;
endpackage

// File: rtl/regset_decode.sv
// Module: regset_decode
// Turns a binary register number into a one-hot select vector.
// Assumes: N <= 2**AW; numbers at or above N select nothing.
module regset_decode #(
    parameter int N  = 4,
    parameter int AW = 2
) (
    input  logic [AW-1:0] num,
    output logic [N-1:0]  hot
);
    // one-hot decode of the register number
    always_comb begin
        for (int i = 0; i < N; i++) begin
            hot[i] = (num == AW'(i));
        end
    end
endmodule

// File: rtl/regset_line.sv
// Module: regset_line
// One storage register with its input selector: bus A is captured when
// this register is the bus A load target, otherwise bus B.
// Assumes: hit_a/hit_b already combine each load strobe with this
// register's select; clock-enabled flops, reset synchronous active-low.
module regset_line #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic         hit_a,
    input  logic         hit_b,
    output logic [W-1:0] q
);
    logic         load_en;
    logic [W-1:0] next_d;

    // input selector and write enable
    always_comb begin
        load_en = hit_a | hit_b;
        next_d  = hit_a ? a_in : b_in;
    end

    // storage flops with synchronous clear
    always_ff @(posedge clk) begin
        if (!rst_n)       q <= '0;
        else if (load_en) q <= next_d;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> q == '0);

    // R8
    hold_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit_a || hit_b) |=> $stable(q));

    // R7
    a_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_a |=> q == $past(a_in));

    // R4
    b_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_b && !hit_a) |=> q == $past(b_in));
endmodule

// File: rtl/dual_bus_regset.sv
// Module: dual_bus_regset
// Register set on two shared bidirectional buses. Each bus has a register
// number, a load strobe and a drive strobe; each register has one tri-state
// driver per bus. Assumes: outside agents release a bus whenever its drive
// strobe is high.
module dual_bus_regset #(
    parameter int W    = regset_pkg::REG_W,
    parameter int NREG = regset_pkg::REG_N,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    inout  wire  [W-1:0]  bus_a,
    inout  wire  [W-1:0]  bus_b,
    input  logic          ld_a,
    input  logic          ld_b,
    input  logic          drv_a,
    input  logic          drv_b,
    input  logic [AW-1:0] num_a,
    input  logic [AW-1:0] num_b
);
    logic [NREG-1:0] sel_a, sel_b;
    logic [NREG-1:0] dhot_a, dhot_b;
    logic [NREG-1:0] lhot_a, lhot_b;
    logic [W-1:0]    store [NREG];

    regset_decode #(.N(NREG), .AW(AW)) u_dec_a (.num(num_a), .hot(sel_a));
    regset_decode #(.N(NREG), .AW(AW)) u_dec_b (.num(num_b), .hot(sel_b));

    // per-register load and drive enables
    always_comb begin
        lhot_a = sel_a & {NREG{ld_a}};
        lhot_b = sel_b & {NREG{ld_b}};
        dhot_a = sel_a & {NREG{drv_a}};
        dhot_b = sel_b & {NREG{drv_b}};
    end

    for (genvar i = 0; i < NREG; i++) begin : g_line
        regset_line #(.W(W)) u_line (
            .clk   (clk),
            .rst_n (rst_n),
            .a_in  (bus_a),
            .b_in  (bus_b),
            .hit_a (lhot_a[i]),
            .hit_b (lhot_b[i]),
            .q     (store[i])
        );
        assign bus_a = dhot_a[i] ? store[i] : {W{1'bz}};
        assign bus_b = dhot_b[i] ? store[i] : {W{1'bz}};
    end

    // R10
    one_driver_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dhot_a));

    // R10
    one_driver_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dhot_b));

    // R2
    drive_follows_num_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drv_a |-> dhot_a[num_a]);
endmodule

// File: tb/sim_dual_bus_regset.sv
module sim_dual_bus_regset;
    localparam int W = 8;
    localparam int N = 4;
    // bus modes: 0 idle, 1 external write, 2 read, 3 read + load
    localparam int M_IDLE = 0, M_WR = 1, M_RD = 2, M_RDLD = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ld_a = 0, ld_b = 0, drv_a = 0, drv_b = 0;
    logic [1:0] num_a = 0, num_b = 0;
    logic tb_a_en = 0, tb_b_en = 0;
    logic [W-1:0] tb_a_val = 0, tb_b_val = 0;
    wire  [W-1:0] bus_a, bus_b;
    logic [W-1:0] model [N];
    int checks = 0, fails = 0;
    bit done = 0;

    assign bus_a = tb_a_en ? tb_a_val : {W{1'bz}};
    assign bus_b = tb_b_en ? tb_b_val : {W{1'bz}};

    always #2 clk = ~clk;

    dual_bus_regset u0 (
        .clk(clk), .rst_n(rst_n), .bus_a(bus_a), .bus_b(bus_b),
        .ld_a(ld_a), .ld_b(ld_b), .drv_a(drv_a), .drv_b(drv_b),
        .num_a(num_a), .num_b(num_b)
    );

    function automatic logic [W-1:0] next_val(input int mode, input logic [W-1:0] ext,
                                             input logic [W-1:0] cur);
        return (mode == M_WR) ? ext : cur;
    endfunction

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // one cycle: inputs set after the falling edge, reads checked before the rising edge
    task automatic cycle(input int ma, input int na, input logic [W-1:0] va,
                         input int mb, input int nb, input logic [W-1:0] vb,
                         input string tag);
        logic [W-1:0] nx_a, nx_b;
        @(negedge clk);
        num_a = 2'(na); num_b = 2'(nb);
        ld_a  = (ma == M_WR) || (ma == M_RDLD);
        ld_b  = (mb == M_WR) || (mb == M_RDLD);
        drv_a = (ma == M_RD) || (ma == M_RDLD);
        drv_b = (mb == M_RD) || (mb == M_RDLD);
        tb_a_en = (ma == M_WR); tb_a_val = va;
        tb_b_en = (mb == M_WR); tb_b_val = vb;
        #1;
        if (drv_a) check({tag, " R5 busA"}, bus_a, model[na]);
        if (drv_b) check({tag, " R5 busB"}, bus_b, model[nb]);
        nx_b = next_val(mb, vb, model[nb]);
        nx_a = next_val(ma, va, model[na]);
        if (ld_b) model[nb] = nx_b;
        if (ld_a) model[na] = nx_a;   // bus A applied last: it wins a shared target
        @(posedge clk);
    endtask

    task automatic read_all(input string tag);
        for (int r = 0; r < N; r++) begin
            cycle(M_RD, r, 0, M_RD, N - 1 - r, 0, tag);
        end
    endtask

    initial begin
        int seed;
        seed = $urandom(32'h0C0FFEE);
        for (int r = 0; r < N; r++) model[r] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: reset clears every register; R2: each number reaches its register
        read_all("R1 R2 after reset");

        // R3 / R2: write distinct values via A, read via B
        for (int r = 0; r < N; r++) cycle(M_WR, r, 8'hA0 + 8'(r), M_IDLE, 0, 0, "R3 write A");
        for (int r = 0; r < N; r++) cycle(M_IDLE, 0, 0, M_RD, r, 0, "R3 R2 readback B");

        // R4: write via B, read via A
        for (int r = 0; r < N; r++) cycle(M_IDLE, 0, 0, M_WR, r, 8'h50 + 8'(r), "R4 write B");
        for (int r = 0; r < N; r++) cycle(M_RD, r, 0, M_IDLE, 0, 0, "R4 readback A");

        // R6: read register 2 on B while A writes it: old then new
        cycle(M_WR, 2, 8'h3C, M_RD, 2, 0, "R6 same-cycle old");
        check("R6 model old value", model[2], 8'h3C);
        cycle(M_IDLE, 0, 0, M_RD, 2, 0, "R6 new value");

        // R7: both buses load register 3, A wins
        cycle(M_WR, 3, 8'h11, M_WR, 3, 8'h22, "R7 dual load");
        cycle(M_RD, 3, 0, M_IDLE, 0, 0, "R7 A wins");
        check("R7 expected 11", model[3], 8'h11);

        // R8: drives only, no loads: nothing changes
        cycle(M_RD, 0, 0, M_RD, 1, 0, "R8 drive only");
        cycle(M_RD, 2, 0, M_RD, 3, 0, "R8 drive only");
        read_all("R8 hold");

        // R9: drive + load on same bus keeps value
        cycle(M_RDLD, 1, 0, M_IDLE, 0, 0, "R9 self reload A");
        cycle(M_IDLE, 0, 0, M_RDLD, 0, 0, "R9 self reload B");
        read_all("R9 unchanged");

        // R10: each register alone on each bus yields exact contents
        for (int r = 0; r < N; r++) cycle(M_RD, r, 0, M_RD, r, 0, "R10 single driver");

        // random mix
        for (int k = 0; k < 600; k++) begin
            cycle(int'($urandom_range(3)), int'($urandom_range(3)), 8'($urandom),
                  int'($urandom_range(3)), int'($urandom_range(3)), 8'($urandom),
                  "random");
        end

        // R1: reset after activity
        @(negedge clk); rst_n = 1'b0; ld_a = 0; ld_b = 0; drv_a = 0; drv_b = 0;
        tb_a_en = 0; tb_b_en = 0;
        @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        for (int r = 0; r < N; r++) model[r] = '0;
        read_all("R1 mid-run reset");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule